// File: doc/BRIEF.md
# Pulse-Count Decimal Accumulator

This block holds a signed ten-digit decimal number and adds to it the way an electromechanical counting register would. Each digit is a decade counter that steps once for each unit pulse arriving on its own line. A digit that wraps from 9 to 0 does not pass its carry on at once. It sets a per-digit carry flag, and every flag is resolved in a dedicated carry slot later in the same addition time. The sign is a one-bit position above the top digit. A negative number is kept as the minus flag together with the ten's complement of its magnitude, so every addition is a plain sum modulo 2·10^10 over the eleven positions.

The block does nothing until a program slot is triggered. Each slot selects an operation from a small set. It can receive pulses from one of several pulse-input groups, send the value as pulse trains on a direct output group, on a complement output group, or on both, or do nothing. A slot can also carry a clear option. The higher-numbered slots additionally carry a repeat count. An addition time is a fixed window of phase slots. Pulse trains occupy the first nine phases, the complement unit pulse comes after them, then the carry slot, and the remaining phases are idle. When the last repetition ends, the block raises a one-cycle completion bit for the slot that ran.

Top module: `pulse_accumulator`

## Requirements
- R1: After reset the readout is zero with the plus sign (`acc_minus` = 0), and all pulse outputs and completion bits are low.
- R2: While a receive program runs, each pulse in phases 0 to 9 on digit line i of the selected input group advances digit i by one, from 9 wrapping to 0. A pulse on the group's sign line (bit NDIG of the group) toggles the sign. Pulses on the other groups are not counted.
- R3: In phase 10 every wrap recorded in phases 0 to 9 is added into the next higher digit, rippling through digits at 9. A carry out of the top digit toggles the sign. The result is the eleven-position sum modulo 2·10^10.
- R4: A negative value v is held as `acc_minus` = 1 with digits equal to 10^10 − |v|.
- R5: A direct send (op 9) pulses digit line i of `tx_direct` d_i times within phases 0 to 8. It pulses the sign line once in phase 0 if the value is negative. The held value does not change.
- R6: A complement send (op 11) pulses digit line i of `tx_comp` (9 − d_i) times within phases 0 to 8, plus one more pulse on line 0 in phase 9. It pulses the sign line once in phase 0 if the value is positive.
- R7: Op 10 drives both pulse groups in the same addition time.
- R8: Op codes 0 to NIN−1 receive from input group k = code, and op 8 is no operation. Codes above 11 also act as no operation and leave the value unchanged.
- R9: The clear option on a receive program zeroes the value, sign included, at the cycle the trigger is sampled, before any pulse is counted. On any other program it zeroes the value when the program completes.
- R10: Slots with index REP_FROM and above run for r addition times, where r is their repeat field, and a field of 0 counts as 1. Lower slots always run for one addition time, whatever their repeat field holds.
- R11: The completion bit of the slot that ran is high for exactly one cycle. That cycle begins 20·r clock edges after the edge that sampled the trigger, and the final value is on the readout in that cycle.
- R12: Triggers that arrive while a program runs are ignored. When several triggers arrive together, the lowest slot index runs.
- R13: Pulses on the input groups change nothing while no receive program is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pulse-phase clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_go | input | NPROG | One trigger bit per program slot |
| prog_op | input | 4·NPROG | Operation code of each slot, slot k in bits 4k+3:4k |
| prog_clr | input | NPROG | Clear option of each slot |
| prog_rep | input | REP_W·NPROG | Repeat field of each slot |
| rx_pulse | input | NIN·(NDIG+1) | Pulse input groups; group k starts at bit k·(NDIG+1), digit lines first with the least significant digit lowest, then the sign line |
| tx_direct | output | NDIG+1 | True-value pulse lines, digits then sign |
| tx_comp | output | NDIG+1 | Complement pulse lines, digits then sign |
| prog_done | output | NPROG | One-cycle completion bit per slot |
| acc_digits | output | 4·NDIG | Held digits in BCD, the least significant digit lowest |
| acc_minus | output | 1 | Held sign, 1 for minus |

## Verification
A trigger sampled at one clock edge produces the completion bit 20·r edges later. The final value is on the readout in that same cycle. Every send pulse falls inside phases 0 to 9 of its addition time. The bench records the cycle count at the moment it drives each trigger and pushes the due cycle into the scoreboard entry together with the expected value and the expected pulse counts per line. The monitor samples on the falling edge, adds up the send pulses over the whole program, and compares everything at the completion bit, including whether it arrived in exactly the due cycle. Receive pulses are driven on falling edges so that phase p's pattern is already present at the edge that processes phase p.

// File: rtl/pca_pkg.sv
package pca_pkg;
   localparam int DIG_W       = 4;
   localparam int OP_W        = 4;
   localparam int PULSE_SLOTS = 9;    // phases 0..8 carry digit pulses
   localparam int UNIT_SLOT   = 9;    // complement unit pulse
   localparam int CARRY_SLOT  = 10;   // deferred carry resolution

   localparam logic [OP_W-1:0] OP_NOP     = 4'd8;
   localparam logic [OP_W-1:0] OP_SEND_A  = 4'd9;
   localparam logic [OP_W-1:0] OP_SEND_AS = 4'd10;
   localparam logic [OP_W-1:0] OP_SEND_S  = 4'd11;

   function automatic logic op_sends_direct(input logic [OP_W-1:0] op);
      return (op == OP_SEND_A) || (op == OP_SEND_AS);
   endfunction

   function automatic logic op_sends_comp(input logic [OP_W-1:0] op);
      return (op == OP_SEND_S) || (op == OP_SEND_AS);
   endfunction
endpackage

// File: rtl/pca_decade.sv
module pca_decade
   import pca_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             pulse,
   input  logic             carry_en,
   input  logic             cin,
   output logic [DIG_W-1:0] digit,
   output logic             cout
);
   logic wrap_q;
   logic at_nine;

   assign at_nine = (digit == 4'd9);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         digit  <= '0;
         wrap_q <= 1'b0;
      end else if (clr) begin
         digit  <= '0;
         wrap_q <= 1'b0;
      end else if (carry_en) begin
         if (cin) digit <= at_nine ? 4'd0 : digit + 4'd1;
         wrap_q <= 1'b0;
      end else if (pulse) begin
         digit <= at_nine ? 4'd0 : digit + 4'd1;
         if (at_nine) wrap_q <= 1'b1;
      end
   end

   assign cout = carry_en && (wrap_q || (at_nine && cin));

   assert_digit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      digit <= 4'd9);

   assert_carry_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      carry_en |=> !wrap_q);
endmodule

// File: rtl/pca_seq.sv
module pca_seq
   import pca_pkg::*;
#(
   parameter int NPROG    = 12,
   parameter int NIN      = 5,
   parameter int REP_W    = 4,
   parameter int REP_FROM = 4,
   parameter int SLOTS    = 20,
   localparam int PH_W    = $clog2(SLOTS),
   localparam int SLOT_W  = $clog2(NPROG)
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPROG-1:0]       go,
   input  logic [NPROG*OP_W-1:0]  cfg_op,
   input  logic [NPROG-1:0]       cfg_clr,
   input  logic [NPROG*REP_W-1:0] cfg_rep,
   output logic                   busy,
   output logic [PH_W-1:0]        phase,
   output logic [OP_W-1:0]        cur_op,
   output logic                   rx_win,
   output logic                   carry_en,
   output logic                   clr_now,
   output logic [NPROG-1:0]       done
);
   localparam logic [OP_W-1:0] NIN_C   = OP_W'(NIN);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLOTS - 1);

   logic [REP_W-1:0]  eff_rep [NPROG];
   logic [REP_W-1:0]  rep_left;
   logic [SLOT_W-1:0] slot_q, pick_idx;
   logic              pick_ok, pick_clr, pick_recv, clr_q, cur_recv;
   logic [OP_W-1:0]   pick_op;
   logic              last_ph, last_rep;

   // Repeat support exists only on the upper slots
   for (genvar g = 0; g < NPROG; g++) begin : g_rep
      if (g >= REP_FROM) begin : g_counted
         logic [REP_W-1:0] fld;
         assign fld        = cfg_rep[g*REP_W +: REP_W];
         assign eff_rep[g] = (fld == '0) ? REP_W'(1) : fld;
      end else begin : g_single
         assign eff_rep[g] = REP_W'(1);
      end
   end

   always_comb begin
      pick_ok  = 1'b0;
      pick_idx = '0;
      for (int i = NPROG - 1; i >= 0; i--) begin
         if (go[i]) begin
            pick_ok  = 1'b1;
            pick_idx = SLOT_W'(i);
         end
      end
   end

   assign pick_op   = cfg_op[pick_idx*OP_W +: OP_W];
   assign pick_clr  = cfg_clr[pick_idx];
   assign pick_recv = pick_op < NIN_C;
   assign last_ph   = (phase == LAST_PH);
   assign last_rep  = (rep_left == REP_W'(1));
   assign cur_recv  = busy && (cur_op < NIN_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         phase    <= '0;
         rep_left <= '0;
         slot_q   <= '0;
         cur_op   <= OP_NOP;
         clr_q    <= 1'b0;
         done     <= '0;
      end else begin
         done <= '0;
         if (!busy) begin
            if (pick_ok) begin
               busy     <= 1'b1;
               phase    <= '0;
               slot_q   <= pick_idx;
               cur_op   <= pick_op;
               clr_q    <= pick_clr;
               rep_left <= eff_rep[pick_idx];
            end
         end else if (last_ph) begin
            phase <= '0;
            if (last_rep) begin
               busy         <= 1'b0;
               done[slot_q] <= 1'b1;
            end else begin
               rep_left <= rep_left - REP_W'(1);
            end
         end else begin
            phase <= phase + PH_W'(1);
         end
      end
   end

   assign rx_win   = cur_recv && (phase <= PH_W'(UNIT_SLOT));
   assign carry_en = cur_recv && (phase == PH_W'(CARRY_SLOT));
   assign clr_now  = (!busy && pick_ok && pick_clr && pick_recv) ||
                     (busy && last_ph && last_rep && clr_q && !cur_recv);

   assert_done_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done));

   assert_done_after_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|done) |-> (!busy && $past(busy)));

   assert_slot_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(slot_q) && $stable(cur_op)));
endmodule

// File: rtl/pca_tx.sv
module pca_tx
   import pca_pkg::*;
#(
   parameter int NDIG = 10,
   parameter int PH_W = 5
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  busy,
   input  logic [PH_W-1:0]       phase,
   input  logic [OP_W-1:0]       op,
   input  logic [NDIG*DIG_W-1:0] digits,
   input  logic                  minus,
   output logic [NDIG:0]         tx_direct,
   output logic [NDIG:0]         tx_comp
);
   logic dir_on, comp_on, in_train;

   assign dir_on   = busy && op_sends_direct(op);
   assign comp_on  = busy && op_sends_comp(op);
   assign in_train = phase < PH_W'(PULSE_SLOTS);

   for (genvar i = 0; i < NDIG; i++) begin : g_line
      logic [DIG_W-1:0] d, nd;
      assign d  = digits[i*DIG_W +: DIG_W];
      assign nd = 4'd9 - d;
      assign tx_direct[i] = dir_on && in_train && (phase < PH_W'(d));
      if (i == 0) begin : g_unit
         assign tx_comp[i] = comp_on && ((in_train && (phase < PH_W'(nd))) ||
                                         (phase == PH_W'(UNIT_SLOT)));
      end else begin : g_plain
         assign tx_comp[i] = comp_on && in_train && (phase < PH_W'(nd));
      end
   end

   assign tx_direct[NDIG] = dir_on  && (phase == '0) && minus;
   assign tx_comp[NDIG]   = comp_on && (phase == '0) && !minus;

   assert_tx_quiet_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase > PH_W'(UNIT_SLOT)) |-> (tx_direct == '0 && tx_comp == '0));

   assert_tx_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (tx_direct == '0 && tx_comp == '0));
endmodule

// File: rtl/pulse_accumulator.sv
module pulse_accumulator
   import pca_pkg::*;
#(
   parameter int NDIG     = 10,
   parameter int NIN      = 5,
   parameter int NPROG    = 12,
   parameter int REP_W    = 4,
   parameter int REP_FROM = 4,
   parameter int SLOTS    = 20
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPROG-1:0]         prog_go,
   input  logic [NPROG*4-1:0]       prog_op,
   input  logic [NPROG-1:0]         prog_clr,
   input  logic [NPROG*REP_W-1:0]   prog_rep,
   input  logic [NIN*(NDIG+1)-1:0]  rx_pulse,
   output logic [NDIG:0]            tx_direct,
   output logic [NDIG:0]            tx_comp,
   output logic [NPROG-1:0]         prog_done,
   output logic [NDIG*4-1:0]        acc_digits,
   output logic                     acc_minus
);
   localparam int LINES = NDIG + 1;
   localparam int PH_W  = $clog2(SLOTS);

   initial begin
      assert (NIN >= 1 && NIN <= 8) else $error("NIN must be 1..8");
      assert (SLOTS > CARRY_SLOT) else $error("SLOTS too small for carry slot");
      assert (NPROG >= 2 && REP_FROM <= NPROG) else $error("bad slot parameters");
      assert (REP_W >= 1) else $error("REP_W must be positive");
   end

   logic              busy, rx_win, carry_en, clr_now, minus_q;
   logic [PH_W-1:0]   phase;
   logic [OP_W-1:0]   cur_op;
   logic [LINES-1:0]  grp [NIN];
   logic [LINES-1:0]  sel;
   logic [NDIG:0]     chain;

   pca_seq #(
      .NPROG(NPROG), .NIN(NIN), .REP_W(REP_W), .REP_FROM(REP_FROM), .SLOTS(SLOTS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(prog_go), .cfg_op(prog_op), .cfg_clr(prog_clr),
      .cfg_rep(prog_rep), .busy(busy), .phase(phase), .cur_op(cur_op),
      .rx_win(rx_win), .carry_en(carry_en), .clr_now(clr_now), .done(prog_done)
   );

   for (genvar k = 0; k < NIN; k++) begin : g_grp
      assign grp[k] = rx_pulse[k*LINES +: LINES];
   end

   always_comb begin
      sel = '0;
      for (int k = 0; k < NIN; k++) begin
         if (cur_op == OP_W'(k)) sel = grp[k];
      end
   end

   assign chain[0] = 1'b0;

   for (genvar i = 0; i < NDIG; i++) begin : g_dec
      pca_decade u_dec (
         .clk(clk), .rst_n(rst_n), .clr(clr_now),
         .pulse(rx_win && sel[i]), .carry_en(carry_en),
         .cin(chain[i]), .digit(acc_digits[i*DIG_W +: DIG_W]), .cout(chain[i+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               minus_q <= 1'b0;
      else if (clr_now)                         minus_q <= 1'b0;
      else if ((rx_win && sel[NDIG]) ^ chain[NDIG]) minus_q <= !minus_q;
   end

   assign acc_minus = minus_q;

   pca_tx #(.NDIG(NDIG), .PH_W(PH_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .busy(busy), .phase(phase), .op(cur_op),
      .digits(acc_digits), .minus(minus_q), .tx_direct(tx_direct), .tx_comp(tx_comp)
   );

   assert_rx_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_win && !carry_en && !clr_now) |=> ($stable(acc_digits) && $stable(acc_minus)));

   assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_now |=> (acc_digits == '0 && !acc_minus));
endmodule

// File: tb/pulse_accumulator_tb.sv
module pulse_accumulator_tb;
   localparam int NDIG = 10, NIN = 5, NPROG = 12, REP_W = 4, LINES = NDIG + 1;
   localparam longint HALF = 64'd10000000000;
   localparam longint MOD  = 64'd20000000000;

   typedef struct {
      int              slot;
      longint          val;
      int              due;
      logic [10:0][7:0] a;
      logic [10:0][7:0] s;
      string           tag;
   } item_t;

   logic clk = 0, rst_n = 0;
   logic [NPROG-1:0]        go = '0;
   logic [NPROG*4-1:0]      prog_op;
   logic [NPROG-1:0]        prog_clr;
   logic [NPROG*REP_W-1:0]  prog_rep;
   logic [NIN*LINES-1:0]    rx = '0;
   logic [NDIG:0]           tx_direct, tx_comp;
   logic [NPROG-1:0]        prog_done;
   logic [NDIG*4-1:0]       acc_digits;
   logic                    acc_minus;

   logic [3:0] cop  [NPROG];
   logic       cclr [NPROG];
   logic [3:0] crep [NPROG];

   int nchk = 0, nerr = 0, cyc = 0;
   longint model = 0;
   item_t q[$];
   logic [10:0][7:0] ca = '0, cs = '0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always_comb begin
      for (int i = 0; i < NPROG; i++) begin
         prog_op[i*4 +: 4]         = cop[i];
         prog_clr[i]               = cclr[i];
         prog_rep[i*REP_W +: REP_W] = crep[i];
      end
   end

   pulse_accumulator u_dut (
      .clk(clk), .rst_n(rst_n), .prog_go(go), .prog_op(prog_op), .prog_clr(prog_clr),
      .prog_rep(prog_rep), .rx_pulse(rx), .tx_direct(tx_direct), .tx_comp(tx_comp),
      .prog_done(prog_done), .acc_digits(acc_digits), .acc_minus(acc_minus)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int dg(input longint e, input int i);
      longint m = e % HALF;
      for (int k = 0; k < i; k++) m = m / 10;
      return int'(m % 10);
   endfunction

   function automatic longint rd_val();
      longint v = 0;
      for (int i = NDIG - 1; i >= 0; i--) v = v * 10 + longint'(acc_digits[i*4 +: 4]);
      return v + (acc_minus ? HALF : 64'd0);
   endfunction

   function automatic int eff_rep(input int s);
      if (s >= 4 && crep[s] != 0) return int'(crep[s]);
      return 1;
   endfunction

   // Monitor: accumulate send pulses, compare at each completion bit
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i <= NDIG; i++) begin
            if (tx_direct[i]) ca[i] = ca[i] + 8'd1;
            if (tx_comp[i])   cs[i] = cs[i] + 8'd1;
         end
         if (prog_done != '0) begin
            if (q.size() == 0) begin
               chk(0, "R12", "completion with no program pending", longint'(prog_done), 0);
            end else begin
               item_t it;
               it = q.pop_front();
               chk(prog_done == (NPROG'(1) << it.slot), "R11", "done slot",
                   longint'(prog_done), longint'(NPROG'(1) << it.slot));
               chk(cyc == it.due, "R11", "done cycle", cyc, it.due);
               chk(rd_val() == it.val, it.tag, "value at done", rd_val(), it.val);
               chk(ca == it.a, "R5", "direct pulse counts", longint'(ca[10:4]), longint'(it.a[10:4]));
               chk(ca[3:0] == it.a[3:0], "R5", "direct low counts", longint'(ca[3:0]), longint'(it.a[3:0]));
               chk(cs == it.s, "R6", "complement pulse counts", longint'(cs[10:4]), longint'(it.s[10:4]));
               chk(cs[3:0] == it.s[3:0], "R6", "complement low counts", longint'(cs[3:0]), longint'(it.s[3:0]));
            end
            ca = '0;
            cs = '0;
         end
      end
   end

   // Driver: compute expectation, push it, trigger, stream the pulse phases
   task automatic run_op(input int s, input longint src, input bit comp, input int noise,
                         input int extra, input int intr, input string tag);
      int rep = eff_rep(s);
      logic [3:0] op = cop[s];
      bit recv = (op < 4'(NIN));
      longint x = comp ? (MOD - src) % MOD : src;
      item_t it;
      it.slot = s; it.tag = tag; it.a = '0; it.s = '0;
      if (recv) begin
         model = ((cclr[s] ? 64'd0 : model) + longint'(rep) * x) % MOD;
      end else begin
         if (op == 4'd9 || op == 4'd10) begin
            for (int i = 0; i < NDIG; i++) it.a[i] = 8'(rep * dg(model, i));
            it.a[10] = 8'(rep * ((model >= HALF) ? 1 : 0));
         end
         if (op == 4'd10 || op == 4'd11) begin
            for (int i = 0; i < NDIG; i++) it.s[i] = 8'(rep * (9 - dg(model, i)) + ((i == 0) ? rep : 0));
            it.s[10] = 8'(rep * ((model < HALF) ? 1 : 0));
         end
         if (cclr[s]) model = 0;
      end
      it.val = model;
      @(negedge clk);
      go = (NPROG'(1) << s) | NPROG'(extra);
      it.due = cyc + 20 * rep + 1;
      q.push_back(it);
      for (int j = 0; j < rep; j++) begin
         for (int p = 0; p < 20; p++) begin
            @(negedge clk);
            go = '0;
            if (j == 0 && p == 5) go = NPROG'(intr);
            rx = '0;
            if (recv && p <= 9) begin
               for (int i = 0; i < NDIG; i++) begin
                  int c = comp ? 9 - dg(src, i) : dg(src, i);
                  rx[int'(op)*LINES + i] = (p < 9 && p < c) || (comp && i == 0 && p == 9);
               end
               rx[int'(op)*LINES + NDIG] = (p == 0) && (comp ? (src < HALF) : (src >= HALF));
            end
            if (noise >= 0) rx[noise*LINES +: LINES] = '1;
         end
      end
      @(negedge clk);
      rx = '0;
      go = '0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < NPROG; i++) begin cop[i] = 4'd8; cclr[i] = 1'b0; crep[i] = 4'd0; end
      cop[0] = 4'd0; cop[1] = 4'd1; cclr[1] = 1'b1; crep[1] = 4'd3;
      cop[2] = 4'd9; cop[3] = 4'd11; cop[4] = 4'd10; crep[4] = 4'd2;
      cop[5] = 4'd2; crep[5] = 4'd3; cop[6] = 4'd9; cclr[6] = 1'b1;
      cop[8] = 4'd3; cop[9] = 4'd15;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(rd_val() == 0, "R1", "reset value", rd_val(), 0);
      chk(tx_direct == '0 && tx_comp == '0, "R1", "reset pulse outputs", longint'(tx_direct), 0);
      chk(prog_done == '0, "R1", "reset completion", longint'(prog_done), 0);

      run_op(0, 15, 0, -1, 0, 0, "R2");                 // receive on group 0
      run_op(8, 27, 0, 1, 0, 0, "R3");                  // 5+7 carry; group 1 noise ignored
      run_op(2, 0, 0, 4, 0, 0, "R5");                   // direct send, rx ignored (R13)
      run_op(3, 0, 0, -1, 0, 0, "R6");                  // complement send
      run_op(0, 64'd9999999958, 0, -1, 0, 0, "R3");     // ripple to sign toggle
      chk(acc_minus == 1'b1 && acc_digits == '0, "R3", "top carry toggles sign",
          longint'(acc_minus), 1);
      run_op(1, 15, 0, -1, 0, 0, "R9");                 // clear-then-load, repeat ignored (R10)
      run_op(0, 27, 1, -1, 0, 0, "R4");                 // add minus 27
      chk(rd_val() == MOD - 12, "R4", "negative held as complement", rd_val(), MOD - 12);
      run_op(4, 0, 0, -1, 0, 0, "R7");                  // both groups, two repeats
      run_op(5, 7, 0, -1, 0, 0, "R10");                 // three repeats of 7
      run_op(0, 5, 0, -1, 0, 1 << 2, "R12");            // intruding trigger ignored
      run_op(3, 0, 0, -1, 1 << 7, 0, "R12");            // lowest index wins
      run_op(9, 0, 0, 0, 0, 0, "R8");                   // undefined code is no-op
      run_op(7, 0, 0, -1, 0, 0, "R8");                  // explicit no-op
      run_op(6, 0, 0, -1, 0, 0, "R9");                  // send then clear
      chk(rd_val() == 0, "R9", "cleared after send", rd_val(), 0);

      rx = '1;                                          // idle pulses
      repeat (5) @(negedge clk);
      rx = '0;
      @(negedge clk);
      chk(rd_val() == 0, "R13", "idle pulses ignored", rd_val(), 0);

      run_op(0, HALF - 1, 0, -1, 0, 0, "R2");
      run_op(0, 1, 0, -1, 0, 0, "R3");                  // all nines plus one
      chk(rd_val() == HALF, "R3", "full ripple", rd_val(), HALF);

      repeat (5) @(negedge clk);
      chk(q.size() == 0, "R11", "completions missing", q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      #1200000;
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule